// File: doc/BRIEF.md
# Phased Tag-First Set-Associative Read Cache

This block is a read-only cache controller. It has four ways, 128 sets and 32-byte lines, which makes 16 KiB. Every lookup is split into two phases so that a hit switches on only one data way. In the first cycle after a request is accepted, the set index is decoded and the four tag ways of that set are read and compared. No data way is enabled in that cycle. If one way matches, the following cycle reads that way's data alone and returns the requested 32-bit word.

On a miss, no data array is read. The block asks a backing memory for the line and keeps its request port closed while it waits. It writes the returned line into a victim way and then answers the original request from the new line. The victim is the first way in the set that holds no valid line. If every way is valid, the victim is the way that was used least recently. Recency is updated on every hit and on every refill.

Two activity outputs count how many tag subarrays and how many data subarrays are enabled in each cycle. Power studies can integrate these counts over a workload.

Top module: `phased_cache`

## Requirements
- R1: A 32-bit byte address is split as follows: bits [4:0] are the line offset, bits [11:5] select one of 128 sets, and bits [31:12] are the tag. The word returned is the one selected by bits [4:2].
- R2: In the cycle after an accepted request (reqValid high while reqReady is high), tagActive equals 4 and dataActive equals 0. In that cycle reqReady is low and rspValid is low.
- R3: On a hit, rspValid is high in the cycle after the tag phase. In that cycle rspHit is 1, rspData holds the addressed word, dataActive equals 1 and tagActive equals 0.
- R4: On a miss, no data way is enabled until the refill arrives. During the wait, refReq stays high and refAddr holds the missing address until refValid is seen. reqReady stays low for the whole wait.
- R5: In the cycle after refValid, rspValid is high, rspHit is 0, rspData is the addressed word taken from the refilled line (32-bit word k at refData bits [32k+31:32k]), and dataActive equals 1. The refilled line then hits on later lookups.
- R6: The victim is the lowest-numbered way without a valid line. If all ways are valid, the victim is the least recently used way, where a hit or a refill makes a way the most recent.
- R7: After reset, reqReady is 1 and rspValid, refReq, tagActive and dataActive are 0. reqReady returns to 1 in the cycle after each response.
- R8: Sets are independent: a refill into one set never changes which lines hit in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request valid |
| reqAddr | input | 32 | Byte address of the request |
| reqReady | output | 1 | Cache can accept a request |
| rspValid | output | 1 | Response word valid |
| rspData | output | 32 | Response word |
| rspHit | output | 1 | Response came from a hit (1) or a refill (0) |
| refReq | output | 1 | Line refill requested |
| refAddr | output | 32 | Address of the missing request |
| refValid | input | 1 | Refill line present on refData |
| refData | input | 256 | Full line, word k in bits [32k+31:32k] |
| tagActive | output | 3 | Tag subarrays enabled this cycle |
| dataActive | output | 3 | Data subarrays enabled this cycle |

## Verification
The embedded properties check, on every cycle, the order of the phases. An accepted request must be followed by the tag phase. A tag hit or a refill must be followed by the response. reqReady must stay low while refReq is high, and reqReady must return after each response. The same properties check that no set ever holds two matching tags, that a read targets a valid way, and that a touched way becomes the most recent. The correctness of least-recently-used eviction, of the returned words and of the independence of sets can only be shown by the bench scenarios. These scenarios compare every access against a recency-ordered reference model of each set.

// File: rtl/phased_cache_pkg.sv
package phased_cache_pkg;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // latch the request address
    logic lookup;   // tag phase: read and compare all tag ways
    logic fill;     // write the refilled line into the chosen way
    logic read;     // data phase: read the single chosen data way
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TAG,
    ST_FILL,
    ST_DATA
  } state_e;

endpackage

// File: rtl/phased_cache_ctrl.sv
module phased_cache_ctrl
  import phased_cache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    tagHit,
  input  logic    refValid,
  output logic    reqReady,
  output logic    rspValid,
  output logic    refReq,
  output strobe_t strobes
);

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobes  = '0;
    reqReady = 1'b0;
    rspValid = 1'b0;
    refReq   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady        = 1'b1;
        strobes.capture = reqValid;
        if (reqValid) stateD = ST_TAG;
      end
      ST_TAG: begin
        strobes.lookup = 1'b1;
        stateD = tagHit ? ST_DATA : ST_FILL;
      end
      ST_FILL: begin
        refReq       = 1'b1;
        strobes.fill = refValid;
        if (refValid) stateD = ST_DATA;
      end
      ST_DATA: begin
        strobes.read = 1'b1;
        rspValid     = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R2: an accepted request is followed by the tag phase
  a_r2_accept_then_tag: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (strobes.lookup && !reqReady && !rspValid));

  // R3: a tag hit is followed by the single-way data read
  a_r3_hit_then_read: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookup && tagHit) |=> (rspValid && strobes.read));

  // R4: the request port stays closed during a refill
  a_r4_closed_in_fill: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> !reqReady);

  // R5: the refill is followed by the response
  a_r5_fill_then_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refValid) |=> rspValid);

  // R7: the port reopens after each response
  a_r7_rsp_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

endmodule

// File: rtl/phased_cache_dp.sv
module phased_cache_dp
  import phased_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int CNT_W     = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LINE_W-1:0] refData,
  output logic              tagHit,
  output logic [ADDR_W-1:0] refAddr,
  output logic [WORD_W-1:0] rspData,
  output logic              rspHit,
  output logic [CNT_W-1:0]  tagActive,
  output logic [CNT_W-1:0]  dataActive
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int WORDS    = LINE_W / WORD_W;
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WAY_W    = $clog2(WAYS);

  logic [TAG_W-1:0]  tagArr  [SETS][WAYS];
  logic [WAYS-1:0]   validArr[SETS];
  logic [WAY_W-1:0]  ageArr  [SETS][WAYS];
  logic [WORD_W-1:0] dataArr [SETS][WAYS][WORDS];

  logic [ADDR_W-1:0] addrQ;
  logic [WAY_W-1:0]  wayQ;
  logic              hitQ;

  logic [IDX_W-1:0]  setQ;
  logic [TAG_W-1:0]  tagQ;
  logic [WSEL_W-1:0] wordQ;
  logic [WAYS-1:0]   matchVec;
  logic [WAY_W-1:0]  hitWay, victim, touchWay;
  logic              touchEn;

  assign setQ  = addrQ[OFF_W +: IDX_W];
  assign tagQ  = addrQ[ADDR_W-1 -: TAG_W];
  assign wordQ = addrQ[BYTE_OFF +: WSEL_W];

  // Tag compare across all ways of the decoded set
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      matchVec[w] = validArr[setQ][w] && (tagArr[setQ][w] == tagQ);
      if (matchVec[w]) hitWay = WAY_W'(w);
    end
  end
  assign tagHit = |matchVec;

  // Victim: lowest invalid way, otherwise the oldest way
  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageArr[setQ][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validArr[setQ][w]) victim = WAY_W'(w);
  end

  assign touchEn  = (strobes.lookup && tagHit) || strobes.fill;
  assign touchWay = strobes.fill ? wayQ : hitWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      wayQ  <= '0;
      hitQ  <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageArr[s][w] <= WAY_W'(w);
      end
    end else begin
      if (strobes.capture) addrQ <= reqAddr;
      if (strobes.lookup) begin
        wayQ <= tagHit ? hitWay : victim;
        hitQ <= tagHit;
      end
      if (strobes.fill) validArr[setQ][wayQ] <= 1'b1;
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[setQ][w] <= '0;
          else if (ageArr[setQ][w] < ageArr[setQ][touchWay])
            ageArr[setQ][w] <= ageArr[setQ][w] + 1'b1;
        end
      end
    end
  end

  // Storage arrays carry no reset; valid bits qualify them
  always_ff @(posedge clk) begin
    if (strobes.fill) begin
      tagArr[setQ][wayQ] <= tagQ;
      for (int k = 0; k < WORDS; k++)
        dataArr[setQ][wayQ][k] <= refData[k*WORD_W +: WORD_W];
    end
  end

  assign refAddr    = addrQ;
  assign rspData    = strobes.read ? dataArr[setQ][wayQ][wordQ] : '0;
  assign rspHit     = hitQ;
  assign tagActive  = strobes.lookup ? CNT_W'(WAYS) : '0;
  assign dataActive = strobes.read ? CNT_W'(1) : '0;

  // Checker state: the way touched in the previous cycle
  logic             touchedQ, filledQ;
  logic [IDX_W-1:0] tSetQ;
  logic [WAY_W-1:0] tWayQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      touchedQ <= 1'b0;
      filledQ  <= 1'b0;
      tSetQ    <= '0;
      tWayQ    <= '0;
    end else begin
      touchedQ <= touchEn;
      filledQ  <= strobes.fill;
      tSetQ    <= setQ;
      tWayQ    <= touchWay;
    end
  end

  // R1: a set never holds two copies of one tag
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookup |-> ($countones(matchVec) <= 1));

  // R3: the data phase only reads a valid way
  a_r3_read_valid_way: assert property (@(posedge clk) disable iff (!rstN)
    strobes.read |-> validArr[setQ][wayQ]);

  // R5: a refilled way is valid afterwards
  a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    filledQ |-> validArr[tSetQ][tWayQ]);

  // R6: a hit or refill makes the way the most recent
  a_r6_touch_is_mru: assert property (@(posedge clk) disable iff (!rstN)
    touchedQ |-> (ageArr[tSetQ][tWayQ] == '0));

endmodule

// File: rtl/phased_cache.sv
module phased_cache
  import phased_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int CNT_W     = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              rspHit,
  output logic              refReq,
  output logic [ADDR_W-1:0] refAddr,
  input  logic              refValid,
  input  logic [LINE_W-1:0] refData,
  output logic [CNT_W-1:0]  tagActive,
  output logic [CNT_W-1:0]  dataActive
);

  strobe_t strobes;
  logic    tagHit;

  phased_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tagHit   (tagHit),
    .refValid (refValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .refReq   (refReq),
    .strobes  (strobes)
  );

  phased_cache_dp #(
    .ADDR_W     (ADDR_W),
    .WAYS       (WAYS),
    .SETS       (SETS),
    .LINE_BYTES (LINE_BYTES),
    .WORD_W     (WORD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .refData    (refData),
    .tagHit     (tagHit),
    .refAddr    (refAddr),
    .rspData    (rspData),
    .rspHit     (rspHit),
    .tagActive  (tagActive),
    .dataActive (dataActive)
  );

endmodule

// File: tb/tb_phased_cache.sv
module tb_phased_cache;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [31:0]  reqAddr;
  logic         reqReady, rspValid, rspHit, refReq, refValid;
  logic [31:0]  rspData, refAddr;
  logic [255:0] refData;
  logic [2:0]   tagActive, dataActive;

  int errors = 0;
  int checks = 0;

  // Reference model: per set, up to 4 tags in recency order (slot 0 = newest)
  logic [19:0] mdlTag[128][4];
  int          mdlCnt[128];

  always #10 clk = ~clk;

  phased_cache dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData), .rspHit(rspHit),
    .refReq(refReq), .refAddr(refAddr), .refValid(refValid), .refData(refData),
    .tagActive(tagActive), .dataActive(dataActive)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'hC0FFEE11;
  endfunction

  function automatic logic [255:0] lineOf(input logic [31:0] a);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = memWord({a[31:5], 3'(k), 2'b00});
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdlAccess(input logic [31:0] a, output bit hit);
    int s;
    int pos;
    logic [19:0] t;
    s = int'(a[11:5]);
    t = a[31:12];
    pos = -1;
    for (int i = 0; i < mdlCnt[s]; i++) if (mdlTag[s][i] == t) pos = i;
    hit = (pos >= 0);
    if (!hit) begin
      if (mdlCnt[s] < 4) mdlCnt[s]++;
      pos = mdlCnt[s] - 1;
    end
    for (int i = pos; i > 0; i--) mdlTag[s][i] = mdlTag[s][i-1];
    mdlTag[s][0] = t;
  endtask

  // One access, checked on every cycle from acceptance to reopening
  task automatic doReq(input logic [31:0] a, input int lat);
    bit expHit;
    int guard;
    guard = 0;
    while (reqReady !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
    chk(reqReady === 1'b1, "R7 ready before request", 32'(reqReady), 32'd1);
    mdlAccess(a, expHit);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(tagActive === 3'd4, "R2 tag ways enabled", 32'(tagActive), 32'd4);
    chk(dataActive === 3'd0, "R2 no data way in tag phase", 32'(dataActive), 32'd0);
    chk(reqReady === 1'b0 && rspValid === 1'b0, "R2 busy, no response", 32'({reqReady, rspValid}), 32'd0);
    @(negedge clk);
    if (expHit) begin
      chk(rspValid === 1'b1, "R3 hit response valid", 32'(rspValid), 32'd1);
      chk(rspHit === 1'b1, "R6 hit predicted by recency model", 32'(rspHit), 32'd1);
      chk(rspData === memWord(a), "R1 R3 hit word", rspData, memWord(a));
      chk(dataActive === 3'd1 && tagActive === 3'd0, "R3 single data way",
          32'({tagActive, dataActive}), 32'd1);
    end else begin
      chk(refReq === 1'b1, "R6 miss predicted by recency model", 32'(refReq), 32'd1);
      for (int i = 0; i < lat; i++) begin
        chk(refReq === 1'b1 && refAddr === a, "R4 refill request held", refAddr, a);
        chk(reqReady === 1'b0 && dataActive === 3'd0, "R4 closed, no data way",
            32'({reqReady, dataActive}), 32'd0);
        @(negedge clk);
      end
      chk(refReq === 1'b1 && refAddr === a, "R4 refill address", refAddr, a);
      refValid = 1'b1;
      refData  = lineOf(a);
      @(negedge clk);
      refValid = 1'b0;
      refData  = '0;
      chk(rspValid === 1'b1 && rspHit === 1'b0, "R5 refill response", 32'({rspValid, rspHit}), 32'd2);
      chk(rspData === memWord(a), "R1 R5 refilled word", rspData, memWord(a));
      chk(dataActive === 3'd1 && tagActive === 3'd0, "R5 single data way",
          32'({tagActive, dataActive}), 32'd1);
    end
    @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0, "R7 reopen after response",
        32'({reqReady, rspValid}), 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int s = 0; s < 128; s++) mdlCnt[s] = 0;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; refValid = 1'b0; refData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R7 reset ready", 32'(reqReady), 32'd1);
    chk(rspValid === 1'b0 && refReq === 1'b0, "R7 reset idle", 32'({rspValid, refReq}), 32'd0);
    chk(tagActive === 3'd0 && dataActive === 3'd0, "R7 reset activity",
        32'({tagActive, dataActive}), 32'd0);

    // Cold miss then hits on other words of the same line (R1, R3, R5)
    doReq(32'h0001_2344, 3);
    doReq(32'h0001_2354, 0);
    doReq(32'h0001_2340, 0);
    doReq(32'h0001_235C, 0);

    // Set 0x1A: tags differ only above bit 11 (R1, R6)
    for (int t = 0; t < 4; t++) doReq({20'(t + 5), 7'h1A, 5'h04}, t);
    doReq({20'd5, 7'h1A, 5'h08}, 0);  // tag 5 becomes newest, tag 6 oldest
    doReq({20'd9, 7'h1A, 5'h10}, 2);  // evicts tag 6
    doReq({20'd6, 7'h1A, 5'h00}, 1);  // miss again, evicts tag 7
    doReq({20'd8, 7'h1A, 5'h1C}, 0);  // still present
    doReq({20'd7, 7'h1A, 5'h0C}, 1);  // evicted earlier

    // Another set filled heavily; set 0x1A must stay intact (R8)
    for (int t = 0; t < 6; t++) doReq({20'(t + 100), 7'h03, 5'h14}, 1);
    doReq({20'd8, 7'h1A, 5'h18}, 0);
    doReq({20'd6, 7'h1A, 5'h04}, 0);

    // Pseudo-random mix over a small pool of tags and sets (R6, R8)
    lcg = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = {20'(lcg[31:29] + 3'd1), (lcg[20] ? 7'h1A : 7'h44), lcg[12:8], 2'b00};
      doReq(a, int'(lcg[5:4]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule